// File: doc/BRIEF.md
# Thermal threshold interrupt monitor

This block watches the raw readings of a small set of on-die temperature sensing points and turns threshold crossings into a sticky interrupt status word. Each reading arrives as a raw code that falls as the die heats up. A single strobe marks the cycle in which all the readings are valid. On each strobe every point is compared against shared thresholds:

- a hot limit and a cold limit;
- a hot-to-normal return level;
- a two-sided offset window.

Each condition can be required to hold for several consecutive samples before it is reported. An external bus-timeout event has a status bit of its own. The enabled status bits are ORed into a single interrupt line.

A separate protection path reduces the points to one value and raises a level alarm when that value is hotter than a protection threshold. The value is either the average, the hottest point, or one chosen point. Software programs the thresholds, the debounce count, the protection settings and the enable word through a simple register port. It clears status bits by writing ones to them. Converting raw codes to degrees and choosing which sensors feed the points are handled elsewhere.

Top module: `thermal_irq_monitor`

## Requirements
- R1: After reset every register reads zero, and irq and prot_alarm are low. Reset is asynchronous and is released through two flops, so the block responds from the third rising edge after rst_n rises.
- R2: On a rising edge with samp_vld high, point p raises status bit 5p+1 (hot) when raw < hot threshold and bit 5p+0 (cold) when raw > cold threshold. The bit is visible right after that edge.
- R3: The offset window sets bit 5p+2 when raw > window-low register (cooler than the window) and bit 5p+3 when raw < window-high register (hotter than the window).
- R4: A point becomes latched-hot when its hot event fires. While latched-hot, a sample with raw > return threshold raises bit 5p+4 and clears the latch; a hot event wins if both would apply.
- R5: Bit 16+p is set on a sample where any of the point's five raw conditions holds before debounce. Bit 19+p is set when any of its debounced events fires.
- R6: A cycle with tmo_evt high sets status bit 15.
- R7: The debounce register (address 9) holds N. A condition fires on its (N+1)-th consecutive qualifying sample and on every further one. A non-qualifying sample restarts the run, and N = 0 fires on the first sample.
- R8: Status bits are sticky. Writing to address 1 clears the bits written as one and leaves the others. A bit set by an event in the same cycle as a clear stays set.
- R9: irq is high exactly when some status bit and its enable bit (address 0, bits 21:0) are both one. An all-zero enable masks irq at once, and the pending status is kept.
- R10: Address 7 holds the protection mode in bits 17:16 and the chosen point in bits 1:0. The modes are: 0 and 3 select the truncated average, 1 selects the lowest raw code (hottest point), and 2 selects the chosen point (point 0 if the index is out of range). On each sample, prot_alarm becomes (value < protection threshold at address 8) and holds between samples.
- R11: The register map is: 0 enable, 1 status, 2 hot, 3 cold, 4 return, 5 window-low, 6 window-high, 7 protection control, 8 protection threshold, 9 debounce. Every register reads back what was written, limited to its width, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | All raw readings valid this cycle |
| raw_in | input | NPTS*RAW_W | Raw readings, point p at bits p*RAW_W upward |
| tmo_evt | input | 1 | Bus timeout event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined enabled interrupt |
| prot_alarm | output | 1 | Protection comparison result |

## Verification
Every result is due at the rising edge that samples its cause:

- status bits, the hot latch and the debounce counters update on the edge that sees samp_vld or tmo_evt;
- prot_alarm updates on the edge that sees samp_vld;
- a register write takes effect on the edge that sees reg_we.

irq and reg_rdata follow the registers combinationally. The bench therefore drives each stimulus on a falling edge and reads the results shortly after the next falling edge, one full edge after the cause. Expected status words come from a bench-side model of the thresholds and of each point's hot latch. The model is stepped once per sample.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  // status word layout
  localparam int GRP_W     = 5;
  localparam int TMO_BIT   = 15;
  localparam int IMM_BASE  = 16;
  localparam int FILT_BASE = 19;
  localparam int STAT_W    = 22;
  localparam int ADDR_W    = 4;

  // bit index inside one point group
  localparam int B_COLD = 0;
  localparam int B_HOT  = 1;
  localparam int B_LOW  = 2;
  localparam int B_HIGH = 3;
  localparam int B_H2N  = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] A_ENABLE = 4'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOT    = 4'd2;
  localparam logic [ADDR_W-1:0] A_COLD   = 4'd3;
  localparam logic [ADDR_W-1:0] A_RETURN = 4'd4;
  localparam logic [ADDR_W-1:0] A_WIN_LO = 4'd5;
  localparam logic [ADDR_W-1:0] A_WIN_HI = 4'd6;
  localparam logic [ADDR_W-1:0] A_PCTL   = 4'd7;
  localparam logic [ADDR_W-1:0] A_PTHR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_DEBNC  = 4'd9;

  typedef enum logic [1:0] {
    PM_AVG     = 2'd0,
    PM_HOTTEST = 2'd1,
    PM_CHOSEN  = 2'd2,
    PM_AVG_ALT = 2'd3
  } pmode_e;
endpackage

// File: rtl/tmon_debounce.sv
module tmon_debounce #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             evt
);
  logic [CNT_W-1:0] run_q, run_d;
  logic             run_en;

  assign evt = smp & cond & (run_q >= limit);

  always_comb begin
    run_en = smp;
    if (!cond)
      run_d = '0;
    else if (run_q >= limit)
      run_d = limit;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (run_en)
      run_q <= run_d;
  end
endmodule

// File: rtl/tmon_point.sv
module tmon_point
  import tmon_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic [RAW_W-1:0] raw,
  input  logic [RAW_W-1:0] thr_hot,
  input  logic [RAW_W-1:0] thr_cold,
  input  logic [RAW_W-1:0] thr_ret,
  input  logic [RAW_W-1:0] win_lo,
  input  logic [RAW_W-1:0] win_hi,
  input  logic [CNT_W-1:0] limit,
  output logic [GRP_W-1:0] evt,
  output logic             imm,
  output logic             filt
);
  logic [GRP_W-1:0] cond_v;
  logic             hot_q, hot_d, hot_en;

  // raw code falls as temperature rises
  always_comb begin
    cond_v         = '0;
    cond_v[B_COLD] = raw > thr_cold;
    cond_v[B_HOT]  = raw < thr_hot;
    cond_v[B_LOW]  = raw > win_lo;
    cond_v[B_HIGH] = raw < win_hi;
    cond_v[B_H2N]  = hot_q & (raw > thr_ret);
  end

  for (genvar k = 0; k < GRP_W; k++) begin : g_db
    tmon_debounce #(.CNT_W(CNT_W)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (smp),
      .cond (cond_v[k]),
      .limit(limit),
      .evt  (evt[k])
    );
  end

  always_comb begin
    hot_en = evt[B_HOT] | evt[B_H2N];
    hot_d  = evt[B_HOT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hot_q <= 1'b0;
    else if (hot_en)
      hot_q <= hot_d;
  end

  assign imm  = smp & (|cond_v);
  assign filt = |evt;
endmodule

// File: rtl/tmon_protect.sv
module tmon_protect
  import tmon_pkg::*;
#(
  parameter int NPTS  = 3,
  parameter int RAW_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp,
  input  logic [NPTS*RAW_W-1:0] raw_all,
  input  logic [1:0]            mode,
  input  logic [1:0]            sel,
  input  logic [RAW_W-1:0]      thr,
  output logic                  alarm
);
  localparam int SUM_W = RAW_W + $clog2(NPTS) + 1;

  logic [SUM_W-1:0] sum_v, avg_full;
  logic [RAW_W-1:0] avg_v, min_v, sel_v, pick_v;
  logic             alarm_d;

  always_comb begin
    sum_v = '0;
    min_v = raw_all[RAW_W-1:0];
    sel_v = raw_all[RAW_W-1:0];
    for (int i = 0; i < NPTS; i++) begin
      sum_v = sum_v + SUM_W'(raw_all[i*RAW_W +: RAW_W]);
      if (raw_all[i*RAW_W +: RAW_W] < min_v)
        min_v = raw_all[i*RAW_W +: RAW_W];
      if (sel == 2'(i))
        sel_v = raw_all[i*RAW_W +: RAW_W];
    end
    avg_full = sum_v / SUM_W'(NPTS);
    avg_v    = avg_full[RAW_W-1:0];
  end

  always_comb begin
    case (pmode_e'(mode))
      PM_HOTTEST: pick_v = min_v;
      PM_CHOSEN:  pick_v = sel_v;
      default:    pick_v = avg_v;
    endcase
    alarm_d = pick_v < thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm <= 1'b0;
    else if (smp)
      alarm <= alarm_d;
  end
endmodule

// File: rtl/thermal_irq_monitor.sv
module thermal_irq_monitor
  import tmon_pkg::*;
#(
  parameter int NPTS  = 3,
  parameter int RAW_W = 12,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  samp_vld,
  input  logic [NPTS*RAW_W-1:0] raw_in,
  input  logic                  tmo_evt,
  input  logic                  reg_we,
  input  logic [3:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq,
  output logic                  prot_alarm
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // configuration registers
  logic [STAT_W-1:0] en_q, stat_q, stat_d, stat_set, stat_clr;
  logic [RAW_W-1:0]  hot_q, cold_q, ret_q, wlo_q, whi_q, pthr_q;
  logic [1:0]        pmode_q, psel_q;
  logic [CNT_W-1:0]  dbc_q;
  logic              wr_en, wr_stat, wr_hot, wr_cold, wr_ret;
  logic              wr_wlo, wr_whi, wr_pctl, wr_pthr, wr_dbc;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata[31:STAT_W];

  always_comb begin
    wr_en   = reg_we && (reg_addr == A_ENABLE);
    wr_stat = reg_we && (reg_addr == A_STATUS);
    wr_hot  = reg_we && (reg_addr == A_HOT);
    wr_cold = reg_we && (reg_addr == A_COLD);
    wr_ret  = reg_we && (reg_addr == A_RETURN);
    wr_wlo  = reg_we && (reg_addr == A_WIN_LO);
    wr_whi  = reg_we && (reg_addr == A_WIN_HI);
    wr_pctl = reg_we && (reg_addr == A_PCTL);
    wr_pthr = reg_we && (reg_addr == A_PTHR);
    wr_dbc  = reg_we && (reg_addr == A_DEBNC);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      hot_q   <= '0;
      cold_q  <= '0;
      ret_q   <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      pmode_q <= '0;
      psel_q  <= '0;
      pthr_q  <= '0;
      dbc_q   <= '0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata[STAT_W-1:0];
      if (wr_hot)  hot_q  <= reg_wdata[RAW_W-1:0];
      if (wr_cold) cold_q <= reg_wdata[RAW_W-1:0];
      if (wr_ret)  ret_q  <= reg_wdata[RAW_W-1:0];
      if (wr_wlo)  wlo_q  <= reg_wdata[RAW_W-1:0];
      if (wr_whi)  whi_q  <= reg_wdata[RAW_W-1:0];
      if (wr_pthr) pthr_q <= reg_wdata[RAW_W-1:0];
      if (wr_dbc)  dbc_q  <= reg_wdata[CNT_W-1:0];
      if (wr_pctl) begin
        pmode_q <= reg_wdata[17:16];
        psel_q  <= reg_wdata[1:0];
      end
    end
  end

  // per-point comparison and debounce (status layout holds up to three points)
  logic [GRP_W-1:0] pt_evt [NPTS];
  logic [NPTS-1:0]  pt_imm, pt_filt;

  for (genvar p = 0; p < NPTS; p++) begin : g_pt
    tmon_point #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_pt (
      .clk     (clk),
      .rst_n   (rst_ni),
      .smp     (samp_vld),
      .raw     (raw_in[p*RAW_W +: RAW_W]),
      .thr_hot (hot_q),
      .thr_cold(cold_q),
      .thr_ret (ret_q),
      .win_lo  (wlo_q),
      .win_hi  (whi_q),
      .limit   (dbc_q),
      .evt     (pt_evt[p]),
      .imm     (pt_imm[p]),
      .filt    (pt_filt[p])
    );
  end

  // sticky status, set has priority over write-one-to-clear
  always_comb begin
    stat_set = '0;
    for (int p = 0; p < NPTS; p++) begin
      stat_set[p*GRP_W +: GRP_W] = pt_evt[p];
      stat_set[IMM_BASE + p]     = pt_imm[p];
      stat_set[FILT_BASE + p]    = pt_filt[p];
    end
    stat_set[TMO_BIT] = tmo_evt;
    stat_clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      stat_q <= '0;
    else
      stat_q <= stat_d;
  end

  assign irq = |(stat_q & en_q);

  // protection path
  tmon_protect #(.NPTS(NPTS), .RAW_W(RAW_W)) u_prot (
    .clk    (clk),
    .rst_n  (rst_ni),
    .smp    (samp_vld),
    .raw_all(raw_in),
    .mode   (pmode_q),
    .sel    (psel_q),
    .thr    (pthr_q),
    .alarm  (prot_alarm)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE: reg_rdata[STAT_W-1:0] = en_q;
      A_STATUS: reg_rdata[STAT_W-1:0] = stat_q;
      A_HOT:    reg_rdata[RAW_W-1:0]  = hot_q;
      A_COLD:   reg_rdata[RAW_W-1:0]  = cold_q;
      A_RETURN: reg_rdata[RAW_W-1:0]  = ret_q;
      A_WIN_LO: reg_rdata[RAW_W-1:0]  = wlo_q;
      A_WIN_HI: reg_rdata[RAW_W-1:0]  = whi_q;
      A_PCTL: begin
        reg_rdata[17:16] = pmode_q;
        reg_rdata[1:0]   = psel_q;
      end
      A_PTHR:   reg_rdata[RAW_W-1:0]  = pthr_q;
      A_DEBNC:  reg_rdata[CNT_W-1:0]  = dbc_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmon_chk.sv
module tmon_chk
  import tmon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              samp_vld,
  input logic              tmo_evt,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              irq,
  input logic              prot_alarm,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q
);
  // R9: an all-zero enable word keeps irq low
  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R8: without a status write no set bit is lost
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STATUS) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6: timeout event lands in bit 15
  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> stat_q[TMO_BIT]);

  // R2: with no sample, timeout or status write the word does not move
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_vld && !tmo_evt && !(reg_we && reg_addr == A_STATUS)) |=> $stable(stat_q));

  // R10: the alarm only changes on a sample
  p_alarm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> $stable(prot_alarm));
endmodule

bind thermal_irq_monitor tmon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .samp_vld  (samp_vld),
  .tmo_evt   (tmo_evt),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .irq       (irq),
  .prot_alarm(prot_alarm),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/sim_thermal_irq_monitor.sv
module sim_thermal_irq_monitor;
  localparam int NP = 3;
  localparam int RW = 12;
  localparam int TH_HOT = 1000, TH_COLD = 3000, TH_RET = 1500;
  localparam int TH_WLO = 2500, TH_WHI = 1200, NEUTRAL = 2000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           samp_vld = 1'b0;
  logic [NP*RW-1:0] raw_in = '0;
  logic           tmo_evt = 1'b0;
  logic           reg_we = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           irq, prot_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit mhot [NP];

  always #10 clk = ~clk;

  thermal_irq_monitor u0 (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .raw_in(raw_in),
    .tmo_evt(tmo_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .prot_alarm(prot_alarm)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic smp(int r0, int r1, int r2);
    @(negedge clk);
    raw_in = {RW'(r2), RW'(r1), RW'(r0)};
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) mhot[i] = 1'b0;
  endtask

  task automatic cfg(int dbc);
    wr(4'd2, TH_HOT);
    wr(4'd3, TH_COLD);
    wr(4'd4, TH_RET);
    wr(4'd5, TH_WLO);
    wr(4'd6, TH_WHI);
    wr(4'd9, dbc);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  // bench model for a debounce count of zero
  function automatic logic [31:0] model(int r0, int r1, int r2);
    int r [NP];
    logic [31:0] e;
    bit c, h, lo, hi, n;
    r[0] = r0; r[1] = r1; r[2] = r2;
    e = '0;
    for (int p = 0; p < NP; p++) begin
      c  = r[p] > TH_COLD;
      h  = r[p] < TH_HOT;
      lo = r[p] > TH_WLO;
      hi = r[p] < TH_WHI;
      n  = mhot[p] && (r[p] > TH_RET);
      e[p*5+0] = c;
      e[p*5+1] = h;
      e[p*5+2] = lo;
      e[p*5+3] = hi;
      e[p*5+4] = n;
      if (c || h || lo || hi || n) begin
        e[16+p] = 1'b1;
        e[19+p] = 1'b1;
      end
      if (h) mhot[p] = 1'b1;
      else if (n) mhot[p] = 1'b0;
    end
    return e;
  endfunction

  task automatic sweep_one(int p, int v);
    int rr [NP];
    logic [31:0] e, a;
    rr[0] = NEUTRAL; rr[1] = NEUTRAL; rr[2] = NEUTRAL;
    rr[p] = v;
    wr(4'd1, 32'hFFFF_FFFF);
    smp(rr[0], rr[1], rr[2]);
    e = model(rr[0], rr[1], rr[2]);
    rd(4'd1, a);
    chk(a == e, "R2 R3 R4 R5 status after sample", a, e);
    chk(irq == (e != 0), "R9 irq follows enabled status", {31'b0, irq}, {31'b0, e != 0});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, e;
    int bnd [11];
    bnd = '{999, 1000, 1001, 1199, 1200, 1500, 1501, 2500, 2501, 3000, 3001};

    do_reset();
    // R1: reset state
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), a);
      chk(a == 0, "R1 register zero after reset", a, 0);
    end
    chk(irq == 0, "R1 irq low after reset", {31'b0, irq}, 0);
    chk(prot_alarm == 0, "R1 alarm low after reset", {31'b0, prot_alarm}, 0);

    // R11: readback and widths
    wr(4'd2, 32'hFFFF_FABC); rd(4'd2, a);
    chk(a == 32'hABC, "R11 hot readback", a, 32'hABC);
    wr(4'd7, 32'hFFFF_FFFE); rd(4'd7, a);
    chk(a == 32'h0003_0002, "R11 protection control readback", a, 32'h0003_0002);
    wr(4'd9, 32'h25); rd(4'd9, a);
    chk(a == 32'h5, "R11 debounce readback", a, 32'h5);
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, a);
    chk(a == 32'h3F_FFFF, "R11 enable readback", a, 32'h3F_FFFF);
    rd(4'd12, a);
    chk(a == 0, "R11 unmapped reads zero", a, 0);

    // R2 R3 R4 R5 sweeps with single-sample debounce (R7 N=0)
    do_reset();
    cfg(0);
    for (int p = 0; p < NP; p++)
      for (int v = 0; v < 4096; v += 39)
        sweep_one(p, v);
    for (int i = 0; i < 11; i++) sweep_one(1, bnd[i]);
    for (int i = 0; i < 11; i++) sweep_one(2, bnd[10-i]);

    // R8: set wins over a same-cycle clear
    do_reset();
    cfg(0);
    @(negedge clk);
    raw_in = {RW'(500), RW'(NEUTRAL), RW'(NEUTRAL)};
    samp_vld = 1'b1; reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    samp_vld = 1'b0; reg_we = 1'b0;
    e = (32'd1 << 11) | (32'd1 << 13) | (32'd1 << 18) | (32'd1 << 21);
    rd(4'd1, a);
    chk(a == e, "R8 event beats clear", a, e);

    // R9: masking keeps status
    wr(4'd0, 0);
    chk(irq == 0, "R9 zero enable masks irq", {31'b0, irq}, 0);
    rd(4'd1, a);
    chk(a == e, "R9 status kept while masked", a, e);
    wr(4'd0, 32'd1 << 11);
    chk(irq == 1, "R9 single enabled bit raises irq", {31'b0, irq}, 1);
    wr(4'd0, 32'd1);
    chk(irq == 0, "R9 non-pending enable keeps irq low", {31'b0, irq}, 0);

    // R8: partial clear
    wr(4'd1, 32'd1 << 11);
    rd(4'd1, a);
    chk(a == (e & ~(32'd1 << 11)), "R8 write-one clears only that bit", a, e & ~(32'd1 << 11));

    // R6: timeout
    wr(4'd1, 32'hFFFF_FFFF);
    @(negedge clk); tmo_evt = 1'b1;
    @(negedge clk); tmo_evt = 1'b0;
    rd(4'd1, a);
    chk(a == (32'd1 << 15), "R6 timeout bit", a, 32'd1 << 15);

    // R7: debounce of two extra samples, then run restart; R4 return event
    do_reset();
    cfg(2);
    for (int k = 0; k < 3; k++) begin
      wr(4'd1, 32'hFFFF_FFFF);
      smp(500, NEUTRAL, NEUTRAL);
      rd(4'd1, a);
      e = (k < 2) ? (32'd1 << 16) : ((32'd1 << 1) | (32'd1 << 3) | (32'd1 << 16) | (32'd1 << 19));
      chk(a == e, "R7 hot fires on third sample", a, e);
    end
    wr(4'd1, 32'hFFFF_FFFF);
    smp(NEUTRAL, NEUTRAL, NEUTRAL);
    rd(4'd1, a);
    chk(a == (32'd1 << 16), "R7 R5 pending return before debounce", a, 32'd1 << 16);
    wr(4'd1, 32'hFFFF_FFFF);
    smp(500, NEUTRAL, NEUTRAL);
    rd(4'd1, a);
    chk(a == (32'd1 << 16), "R7 broken run restarts count", a, 32'd1 << 16);
    for (int k = 0; k < 3; k++) begin
      wr(4'd1, 32'hFFFF_FFFF);
      smp(NEUTRAL, NEUTRAL, NEUTRAL);
      rd(4'd1, a);
      e = (k < 2) ? (32'd1 << 16) : ((32'd1 << 4) | (32'd1 << 16) | (32'd1 << 19));
      chk(a == e, "R4 R7 debounced return to normal", a, e);
    end

    // R10: protection modes
    do_reset();
    wr(4'd8, 1200);
    wr(4'd7, 32'h0000_0000);
    smp(900, 1200, 1500);
    chk(prot_alarm == 0, "R10 average equal to limit", {31'b0, prot_alarm}, 0);
    smp(900, 1200, 1497);
    chk(prot_alarm == 1, "R10 truncated average below limit", {31'b0, prot_alarm}, 1);
    wr(4'd7, 32'h0001_0000);
    smp(1300, 1250, 1500);
    chk(prot_alarm == 0, "R10 hottest above limit", {31'b0, prot_alarm}, 0);
    smp(1300, 1199, 1500);
    chk(prot_alarm == 1, "R10 hottest below limit", {31'b0, prot_alarm}, 1);
    wr(4'd7, 32'h0002_0002);
    smp(100, 100, 1500);
    chk(prot_alarm == 0, "R10 chosen point cool", {31'b0, prot_alarm}, 0);
    smp(2000, 2000, 1100);
    chk(prot_alarm == 1, "R10 chosen point hot", {31'b0, prot_alarm}, 1);
    wr(4'd7, 32'h0002_0003);
    smp(1100, 2000, 2000);
    chk(prot_alarm == 1, "R10 out-of-range choice uses point 0", {31'b0, prot_alarm}, 1);
    wr(4'd7, 32'h0003_0000);
    smp(1300, 1300, 1300);
    chk(prot_alarm == 0, "R10 mode 3 average cool", {31'b0, prot_alarm}, 0);
    smp(1000, 1000, 1000);
    chk(prot_alarm == 1, "R10 mode 3 average hot", {31'b0, prot_alarm}, 1);
    repeat (3) @(negedge clk);
    chk(prot_alarm == 1, "R10 alarm held between samples", {31'b0, prot_alarm}, 1);

    summary();
    $finish;
  end
endmodule